// File: doc/BRIEF.md
# System Management Interrupt Sequencer

This block steers a simple processor model into and out of a privileged management mode. A management request can come from a dedicated request line or from a trap on an I/O access to a powered-down device. When one arrives, the sequencer takes a snapshot of the processor's architectural words. It copies them one word per clock into a protected on-block memory region and adds a control word that records whether the entry came from an I/O trap. Only after the last word is written does it tell the fetch unit to jump to a fixed handler entry address.

While the handler runs, the processor reaches the protected region through a small synchronous bus port. The same port is refused whenever management mode is inactive. When the handler issues a resume strobe, the block reads the saved words back from the region. Any edits the handler made to the region are included. The block then presents the restored state with a return program counter. For a trapped I/O access, that counter points back at the trapped instruction, and a replay flag tells the core to issue the access again. A request that arrives during management mode waits as pending and is served after the exit.

Top module: `smi_sequencer`

## Requirements
- R1: In normal mode, a high `mgmt_req` or `io_trap` starts entry at the next clock edge, whatever the value of `ext_irq_en`. In that same cycle `ext_irq_ack` stays low even when an external interrupt is requested and enabled.
- R2: Entry writes NW words into region addresses 0 to NW-1, one per clock. Addresses 0 to NW-2 hold the NW-1 words of `arch_state_in` sampled at the request edge, with word i taken from bits [i*DW +: DW]. Address NW-1 holds a control word: bit 0 is the restart flag (1 when `io_trap` caused the entry) and all other bits are 0.
- R3: `fetch_redirect` is high for exactly one cycle, with `fetch_pc` equal to HANDLER_ENTRY. It is first seen NW+1 cycles after the request cycle, after every save write. `fetch_pc` is 0 when `fetch_redirect` is low.
- R4: A region access on the bus port is carried out only in the handler phase. Outside that phase, the next cycle shows `cpu_err`=1, `cpu_rvalid`=0 and `cpu_rdata`=0, and the region contents do not change.
- R5: A `resume_strobe` in the handler phase reads the NW region words back. NW+2 cycles after the strobe cycle, `restore_valid` is high for one cycle and `arch_state_out` carries region words 0 to NW-2, including any changes the handler wrote.
- R6: A `resume_strobe` outside the handler phase has no effect: no restore takes place and `mgmt_active` does not change.
- R7: During `restore_valid`, if bit 0 of the restored control word is 1, then `resume_pc` equals restored word 0 minus INSTR_BYTES and `io_replay` is 1. Otherwise `resume_pc` equals restored word 0 and `io_replay` is 0.
- R8: A request (`mgmt_req` or `io_trap`) seen outside normal mode does not cause a new entry or redirect. It is held as pending, with a restart flag set if `io_trap` was part of it. The pending request starts entry two cycles after the `restore_valid` cycle, with no new request needed.
- R9: `mgmt_active` is high from the first save cycle through the last restore cycle. It is low during the `restore_valid` cycle and in normal mode.
- R10: `ext_irq_ack` is high only in normal mode, when `ext_irq_req` and `ext_irq_en` are both high and no management request is present or pending.
- R11: After reset, `mgmt_active`, `fetch_redirect`, `restore_valid`, `cpu_err`, `cpu_rvalid` and `ext_irq_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mgmt_req | input | 1 | Management interrupt request, cannot be masked |
| io_trap | input | 1 | I/O access to a powered-down device; raises a request with restart |
| resume_strobe | input | 1 | Resume instruction executed by the handler |
| ext_irq_req | input | 1 | External interrupt request |
| ext_irq_en | input | 1 | External interrupt enable |
| ext_irq_ack | output | 1 | External interrupt accepted this cycle |
| arch_state_in | input | (NW-1)*DW | Architectural words from the core; word 0 is the next-instruction PC |
| cpu_req | input | 1 | Region bus request |
| cpu_we | input | 1 | Region bus write enable |
| cpu_addr | input | log2(DEPTH) | Region word address |
| cpu_wdata | input | DW | Region write data |
| cpu_rdata | output | DW | Region read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | Read data valid, one cycle after a granted read |
| cpu_err | output | 1 | Previous access was refused |
| mgmt_active | output | 1 | Management mode in progress |
| fetch_redirect | output | 1 | Pulse telling the fetch unit to jump to fetch_pc |
| fetch_pc | output | DW | Handler entry address during the redirect |
| restore_valid | output | 1 | Restored state is on the outputs |
| arch_state_out | output | (NW-1)*DW | Restored architectural words |
| resume_pc | output | DW | Return program counter |
| io_replay | output | 1 | Trapped I/O access must be issued again |

## Verification
The bench builds the block with its defaults: 8 state words of 32 bits, a 64-word region, the handler entry at word 32 and 4-byte instructions. With only eight words, the entry and exit latencies of nine and ten cycles can be checked exactly on every one of several dozen random round trips. The 64-word region leaves room above the state area for a handler-owned word, which shows that refused writes in normal mode leave the region unchanged. The 32-bit words let random snapshots, handler edits and restart-flag toggles produce distinct return counters, including wrap-around when 4 is subtracted.

// File: rtl/smm_pkg.sv
package smm_pkg;

    // Sequencer phases, from normal execution through save, handler and restore.
    typedef enum logic [2:0] {
        SQ_NORMAL  = 3'd0,
        SQ_SAVE    = 3'd1,
        SQ_ENTER   = 3'd2,
        SQ_HANDLER = 3'd3,
        SQ_RESTORE = 3'd4,
        SQ_EXIT    = 3'd5
    } sq_state_t;

endpackage

// File: rtl/smm_region_ram.sv
// smm_region_ram
// Word-wide synchronous memory holding the saved state and handler data.
// Assumes: a single address shared by reads and writes; read data appears
// one cycle after a read enable and holds until the next read.
module smm_region_ram #(
    parameter int DW    = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            if (we) mem[addr] <= wdata;
            if (re) rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/smm_seq_ctrl.sv
// smm_seq_ctrl
// Phase machine and word counter for entry and exit, plus the pending latch.
// Assumes: a request is honoured only in normal mode; anything seen
// elsewhere is held and taken once the block is back in normal mode.
module smm_seq_ctrl
    import smm_pkg::*;
#(
    parameter int NW   = 8,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mgmt_req,
    input  logic            io_trap,
    input  logic            resume_strobe,
    output sq_state_t       state,
    output logic [IDXW-1:0] idx,
    output logic            take,
    output logic            take_restart,
    output logic            pend
);

    localparam logic [IDXW-1:0] LAST_SAVE = IDXW'(NW - 1);
    localparam logic [IDXW-1:0] LAST_REST = IDXW'(NW);

    logic req_now;
    logic pend_restart;

    // Decode of a request that is accepted this cycle.
    always_comb begin
        req_now      = mgmt_req | io_trap;
        take         = (state == SQ_NORMAL) && (req_now || pend);
        take_restart = io_trap || (pend && pend_restart);
    end

    // Phase register and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_NORMAL;
            idx   <= '0;
        end else begin
            case (state)
                SQ_NORMAL: begin
                    if (take) begin
                        state <= SQ_SAVE;
                        idx   <= '0;
                    end
                end
                SQ_SAVE: begin
                    if (idx == LAST_SAVE) begin
                        state <= SQ_ENTER;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_ENTER:   state <= SQ_HANDLER;
                SQ_HANDLER: begin
                    if (resume_strobe) begin
                        state <= SQ_RESTORE;
                        idx   <= '0;
                    end
                end
                SQ_RESTORE: begin
                    if (idx == LAST_REST) begin
                        state <= SQ_EXIT;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default:    state <= SQ_NORMAL;
            endcase
        end
    end

    // Pending latch for requests that arrive outside normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend         <= 1'b0;
            pend_restart <= 1'b0;
        end else if (take) begin
            pend         <= 1'b0;
            pend_restart <= 1'b0;
        end else if (state != SQ_NORMAL && req_now) begin
            pend         <= 1'b1;
            pend_restart <= pend_restart | io_trap;
        end
    end

    AST_PEND_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_NORMAL && (mgmt_req || io_trap)) |=> pend); // R8
    AST_SAVE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SAVE) |-> (idx <= LAST_SAVE)); // R2
    AST_ENTER_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_ENTER) |-> ($past(state) == SQ_SAVE)); // R3

endmodule

// File: rtl/smm_bus_guard.sv
// smm_bus_guard
// Lets processor accesses reach the protected region only while the handler
// runs; refuses them otherwise and reports the refusal one cycle later.
// Assumes: 'open' is high only in the handler phase and the sequencer does
// not use the memory in that phase.
module smm_bus_guard #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [DW-1:0] ram_rdata,
    output logic          g_we,
    output logic          g_re,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rvalid,
    output logic          cpu_err
);

    // Grant decode for the current request.
    always_comb begin
        g_we      = open & cpu_req & cpu_we;
        g_re      = open & cpu_req & ~cpu_we;
        cpu_rdata = cpu_rvalid ? ram_rdata : '0;
    end

    // Read-valid and refusal flags, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            cpu_err    <= 1'b0;
        end else begin
            cpu_rvalid <= g_re;
            cpu_err    <= cpu_req & ~open;
        end
    end

    AST_REFUSED_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> !cpu_rvalid); // R4

endmodule

// File: rtl/smi_sequencer.sv
// smi_sequencer
// Top of the management-mode sequencer: snapshots the architectural words,
// saves them with a control word into the protected region, redirects fetch,
// guards the region, restores on resume and computes the return counter.
// Assumes: NW <= HANDLER_ENTRY < DEPTH; arch_state_in is valid in the cycle a
// request is taken; the state area occupies region addresses 0..NW-1.
module smi_sequencer
    import smm_pkg::*;
#(
    parameter int NW            = 8,
    parameter int DW            = 32,
    parameter int DEPTH         = 64,
    parameter int HANDLER_ENTRY = 32,
    parameter int INSTR_BYTES   = 4,
    localparam int AW           = $clog2(DEPTH),
    localparam int SW           = (NW - 1) * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mgmt_req,
    input  logic          io_trap,
    input  logic          resume_strobe,
    input  logic          ext_irq_req,
    input  logic          ext_irq_en,
    output logic          ext_irq_ack,
    input  logic [SW-1:0] arch_state_in,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_rvalid,
    output logic          cpu_err,
    output logic          mgmt_active,
    output logic          fetch_redirect,
    output logic [DW-1:0] fetch_pc,
    output logic          restore_valid,
    output logic [SW-1:0] arch_state_out,
    output logic [DW-1:0] resume_pc,
    output logic          io_replay
);

    localparam int IDXW = $clog2(NW + 1);

    sq_state_t             state;
    logic [IDXW-1:0]       idx;
    logic                  take;
    logic                  take_restart;
    logic                  pend;

    logic [NW-2:0][DW-1:0] snap;
    logic                  restart_q;
    logic [NW-1:0][DW-1:0] restored;

    logic                  seq_we;
    logic                  seq_re;
    logic [DW-1:0]         save_word;
    logic                  g_we;
    logic                  g_re;
    logic                  ram_we;
    logic                  ram_re;
    logic [AW-1:0]         ram_addr;
    logic [DW-1:0]         ram_wdata;
    logic [DW-1:0]         ram_rdata;
    logic                  restart_bit;

    smm_seq_ctrl #(
        .NW   (NW),
        .IDXW (IDXW)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .mgmt_req      (mgmt_req),
        .io_trap       (io_trap),
        .resume_strobe (resume_strobe),
        .state         (state),
        .idx           (idx),
        .take          (take),
        .take_restart  (take_restart),
        .pend          (pend)
    );

    smm_bus_guard #(
        .DW (DW)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .open       (state == SQ_HANDLER),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .ram_rdata  (ram_rdata),
        .g_we       (g_we),
        .g_re       (g_re),
        .cpu_rdata  (cpu_rdata),
        .cpu_rvalid (cpu_rvalid),
        .cpu_err    (cpu_err)
    );

    smm_region_ram #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

    // Snapshot of the architectural words and the restart cause at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap      <= '0;
            restart_q <= 1'b0;
        end else if (take) begin
            snap      <= arch_state_in;
            restart_q <= take_restart;
        end
    end

    // Word to save at the current index: a snapshot word or the control word.
    always_comb begin
        save_word = {{(DW-1){1'b0}}, restart_q};
        for (int i = 0; i < NW - 1; i++) begin
            if (idx == IDXW'(i)) save_word = snap[i];
        end
    end

    // Memory port sharing between the sequencer and the guarded bus.
    always_comb begin
        seq_we    = (state == SQ_SAVE);
        seq_re    = (state == SQ_RESTORE) && (idx < IDXW'(NW));
        ram_we    = seq_we | g_we;
        ram_re    = seq_re | g_re;
        ram_addr  = (seq_we || seq_re) ? AW'(idx) : cpu_addr;
        ram_wdata = seq_we ? save_word : cpu_wdata;
    end

    // Capture of read-back words, one cycle behind each restore read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restored <= '0;
        end else if (state == SQ_RESTORE) begin
            for (int i = 0; i < NW; i++) begin
                if (idx == IDXW'(i + 1)) restored[i] <= ram_rdata;
            end
        end
    end

    // Status, redirect, interrupt acceptance and restored outputs.
    always_comb begin
        restart_bit    = restored[NW-1][0];
        mgmt_active    = (state == SQ_SAVE) || (state == SQ_ENTER) ||
                         (state == SQ_HANDLER) || (state == SQ_RESTORE);
        fetch_redirect = (state == SQ_ENTER);
        fetch_pc       = fetch_redirect ? DW'(HANDLER_ENTRY) : '0;
        ext_irq_ack    = (state == SQ_NORMAL) && ext_irq_req && ext_irq_en &&
                         !mgmt_req && !io_trap && !pend;
        restore_valid  = (state == SQ_EXIT);
        arch_state_out = restore_valid ? restored[NW-2:0] : '0;
        io_replay      = restore_valid && restart_bit;
        if (!restore_valid)   resume_pc = '0;
        else if (restart_bit) resume_pc = restored[0] - DW'(INSTR_BYTES);
        else                  resume_pc = restored[0];
    end

    AST_REGION_WRITE_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> mgmt_active); // R4
    AST_SAVED_BEFORE_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |-> $past(ram_we)); // R2
    AST_REDIRECT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_redirect |=> !fetch_redirect); // R3
    AST_EXT_QUIET_IN_MGMT: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_active |-> !ext_irq_ack); // R10
    AST_EXIT_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |-> (!mgmt_active && $past(mgmt_active))); // R9

endmodule

// File: tb/tb_smi_sequencer.sv
module tb_smi_sequencer;

    localparam int NW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 64;
    localparam int HENTRY = 32;
    localparam int IBYTES = 4;
    localparam int AW = $clog2(DEPTH);
    localparam int SW = (NW - 1) * DW;
    localparam logic [AW-1:0] SCRATCH = AW'(40);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mgmt_req = 1'b0, io_trap = 1'b0, resume_strobe = 1'b0;
    logic ext_irq_req = 1'b0, ext_irq_en = 1'b0;
    logic ext_irq_ack;
    logic [SW-1:0] arch_state_in = '0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic cpu_rvalid, cpu_err, mgmt_active, fetch_redirect, restore_valid, io_replay;
    logic [DW-1:0] fetch_pc, resume_pc;
    logic [SW-1:0] arch_state_out;

    smi_sequencer #(.NW(NW), .DW(DW), .DEPTH(DEPTH), .HANDLER_ENTRY(HENTRY),
                    .INSTR_BYTES(IBYTES)) dut (.*);

    always #2.5 clk = ~clk;

    int vectors = 0;
    int fails = 0;
    logic [DW-1:0] exp_mem [NW];
    logic [DW-1:0] scratch_val;
    bit pend_exp;
    bit pend_trap;

    // Result accounting for every check.
    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input bit ok_exp, input string tag);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        tick();
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(cpu_err == !ok_exp, tag, cpu_err, !ok_exp);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                            output logic v);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        tick();
        cpu_req = 1'b0;
        d = cpu_rdata; v = cpu_rvalid;
    endtask

    function automatic logic [DW-1:0] ret_pc(input logic [DW-1:0] w0, input bit rs);
        return rs ? w0 - DW'(IBYTES) : w0;
    endfunction

    // Entry from a normal-mode negedge: new request or pending one.
    task automatic entry(input bit trap);
        logic [SW-1:0] st;
        bit rs;
        for (int i = 0; i < NW - 1; i++) st[i*DW +: DW] = $urandom;
        arch_state_in = st;
        ext_irq_req = 1'b1; ext_irq_en = $urandom % 2;
        if (pend_exp) begin
            rs = pend_trap;
            #1 chk(ext_irq_ack == 1'b0, "R10 ack with pending", ext_irq_ack, 0);
            chk(mgmt_active == 1'b0, "R8 normal gap before pending", mgmt_active, 0);
        end else begin
            rs = trap;
            if (trap) io_trap = 1'b1; else mgmt_req = 1'b1;
            #1 chk(ext_irq_ack == 1'b0, "R1 priority over ext irq", ext_irq_ack, 0);
        end
        pend_exp = 0; pend_trap = 0;
        tick();
        mgmt_req = 1'b0; io_trap = 1'b0; ext_irq_req = 1'b0;
        arch_state_in = ~st;
        for (int i = 0; i < NW - 1; i++) exp_mem[i] = st[i*DW +: DW];
        exp_mem[NW-1] = {{(DW-1){1'b0}}, rs};
        for (int k = 1; k <= NW + 1; k++) begin
            chk(mgmt_active == 1'b1, "R9 active during save", mgmt_active, 1);
            chk(fetch_redirect == (k == NW + 1), "R3 redirect timing", fetch_redirect, k);
            if (k < NW + 1) tick();
        end
        chk(fetch_pc == DW'(HENTRY), "R3 handler entry", fetch_pc, HENTRY);
        tick();
        chk(fetch_redirect == 1'b0, "R3 single pulse", fetch_redirect, 0);
    endtask

    // Handler body: verify save, optional edits, optional pending request.
    task automatic handler(input bit first);
        logic [DW-1:0] d;
        logic v;
        for (int i = 0; i < NW; i++) begin
            bus_read(AW'(i), d, v);
            chk(v && d == exp_mem[i], "R2 saved word", d, exp_mem[i]);
        end
        if (first) begin
            scratch_val = $urandom;
            bus_write(SCRATCH, scratch_val, 1, "R4 handler write granted");
        end else begin
            bus_read(SCRATCH, d, v);
            chk(v && d == scratch_val, "R4 blocked write left region", d, scratch_val);
        end
        if ($urandom % 2) begin
            int w = $urandom % (NW - 1);
            exp_mem[w] = $urandom;
            bus_write(AW'(w), exp_mem[w], 1, "R5 handler edit");
        end
        if ($urandom % 3 == 0) begin
            exp_mem[NW-1] = {{(DW-1){1'b0}}, ~exp_mem[NW-1][0]};
            bus_write(AW'(NW - 1), exp_mem[NW-1], 1, "R7 flag edit");
        end
        if ($urandom % 3 == 0) begin
            pend_exp = 1; pend_trap = $urandom % 2;
            if (pend_trap) io_trap = 1'b1; else mgmt_req = 1'b1;
            tick();
            mgmt_req = 1'b0; io_trap = 1'b0;
            chk(fetch_redirect == 1'b0 && mgmt_active, "R8 no nesting", fetch_redirect, 0);
        end
    endtask

    // Resume and check exit timing and restored values.
    task automatic do_exit();
        logic [SW-1:0] exp_out;
        for (int i = 0; i < NW - 1; i++) exp_out[i*DW +: DW] = exp_mem[i];
        resume_strobe = 1'b1;
        tick();
        resume_strobe = 1'b0;
        for (int k = 1; k <= NW + 1; k++) begin
            chk(mgmt_active && !restore_valid, "R9 active during restore", mgmt_active, 1);
            tick();
        end
        chk(restore_valid == 1'b1, "R5 restore timing", restore_valid, 1);
        chk(mgmt_active == 1'b0, "R9 inactive at exit", mgmt_active, 0);
        chk(arch_state_out == exp_out, "R5 restored state", arch_state_out, exp_out);
        chk(resume_pc == ret_pc(exp_mem[0], exp_mem[NW-1][0]), "R7 return pc",
            resume_pc, ret_pc(exp_mem[0], exp_mem[NW-1][0]));
        chk(io_replay == exp_mem[NW-1][0], "R7 replay flag", io_replay, exp_mem[NW-1][0]);
        tick();
        chk(restore_valid == 1'b0, "R5 single pulse", restore_valid, 0);
    endtask

    // Normal-mode probes: refused bus access, stray resume, ext interrupt.
    task automatic normal_probes();
        logic [DW-1:0] d;
        logic v;
        bus_write(SCRATCH, ~scratch_val, 0, "R4 write refused");
        bus_read(SCRATCH, d, v);
        chk(!v && d == '0 && cpu_err, "R4 read refused", {v, d}, 0);
        resume_strobe = 1'b1;
        tick();
        resume_strobe = 1'b0;
        chk(!mgmt_active && !restore_valid, "R6 stray resume ignored", mgmt_active, 0);
        tick();
        chk(!restore_valid && !mgmt_active, "R6 no restore later", restore_valid, 0);
        ext_irq_req = 1'b1; ext_irq_en = $urandom % 2;
        #1 chk(ext_irq_ack == ext_irq_en, "R10 ext ack in normal", ext_irq_ack, ext_irq_en);
        tick();
        ext_irq_req = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) tick();
        chk(!mgmt_active && !fetch_redirect && !restore_valid && !cpu_err &&
            !cpu_rvalid && !ext_irq_ack, "R11 reset state", mgmt_active, 0);
        rst_n = 1'b1;
        tick();
        chk(!mgmt_active && !restore_valid, "R11 after release", mgmt_active, 0);
        for (int it = 0; it < 40; it++) begin
            if (!pend_exp) normal_probes();
            entry(it < 2 ? bit'(it) : bit'($urandom % 2));
            handler(it == 0);
            do_exit();
        end
        tick();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: an overrun counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule